// File: doc/BRIEF.md
# Prioritized Trap Interrupt Selector

This block decides which pending interrupt, if any, the processor core should take next. It looks at five pending flags: hypervisor tick match, interrupt vector, CPU mondo, device mondo and resumable error. It weighs them against the current privilege level (hypervisor mode or not) and the interrupt-enable bit. It returns one winner as a valid flag plus a 3-bit kind code. The logic is purely combinational. The trap sequencer samples the result on whatever cycle it chooses, so the block holds no state.

Whether a source is eligible depends on privilege:
- In hypervisor mode, only the hypervisor tick and the interrupt vector can win, and only while interrupts are enabled.
- Outside hypervisor mode, those two win whatever the enable bit says.
- The three mondo/error sources need interrupts enabled and the core outside hypervisor mode.

Among eligible sources a fixed priority picks the winner. Clearing the pending flags and delivering the trap belong to other logic.

Top module: `trap_irq_arbiter`

## Requirements
- R1: Fixed priority among eligible pending sources, highest first: hypervisor tick, interrupt vector, CPU mondo, device mondo, resumable error; only the highest eligible one is reported.
- R2: With `hyp_mode`=1 and `intr_en`=0, every pending flag is ignored: `take_valid`=0, `take_kind`=0.
- R3: With `hyp_mode`=1 and `intr_en`=1, only hypervisor tick and interrupt vector are eligible; CPU mondo, device mondo and resumable error are never taken.
- R4: With `hyp_mode`=0, a pending hypervisor tick or interrupt vector is taken whatever the value of `intr_en`.
- R5: With `hyp_mode`=0 and `intr_en`=0, CPU mondo, device mondo and resumable error are ignored.
- R6: When no eligible source is pending, `take_valid`=0 and `take_kind`=0.
- R7: Kind codes on `take_kind`: 0 none, 1 hypervisor tick, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 resumable error; `take_valid`=1 exactly when the code is nonzero.
- R8: The outputs follow the inputs combinationally, with no clock edge between a change of input and the new selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_hstick | input | 1 | Hypervisor tick-match interrupt pending |
| pend_vec | input | 1 | Interrupt-vector source pending |
| pend_cpu_mondo | input | 1 | CPU mondo pending |
| pend_dev_mondo | input | 1 | Device mondo pending |
| pend_res_err | input | 1 | Resumable error pending |
| hyp_mode | input | 1 | Core is in hypervisor mode |
| intr_en | input | 1 | Interrupt-enable bit |
| take_valid | output | 1 | An interrupt is selected |
| take_kind | output | 3 | Encoded kind of the selected interrupt |

## Verification
The block has no stored state. A wrong eligibility mask or a broken priority chain therefore shows up at once, in the same evaluation as the offending input, as a wrong kind code or a spurious or missing valid. The bench applies all 128 input combinations, so every mask and priority error is seen on some vector. Directed scenarios pin down the privilege-gated cases, so a failure points to the requirement that was broken.

// File: rtl/trap_irq_pkg.sv
package trap_irq_pkg;

  // Source slots, index 0 is the highest priority.
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned KIND_W  = $clog2(NUM_SRC + 1);

  localparam int unsigned SRC_HSTICK = 0;
  localparam int unsigned SRC_VEC    = 1;
  localparam int unsigned SRC_CPU    = 2;
  localparam int unsigned SRC_DEV    = 3;
  localparam int unsigned SRC_RES    = 4;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE   = 3'd0,
    KIND_HSTICK = 3'd1,
    KIND_VEC    = 3'd2,
    KIND_CPU    = 3'd3,
    KIND_DEV    = 3'd4,
    KIND_RES    = 3'd5
  } irq_kind_e;

endpackage

// File: rtl/trap_irq_gate.sv
module trap_irq_gate
  import trap_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend,
  input  logic               hyp_mode,
  input  logic               intr_en,
  output logic [NUM_SRC-1:0] elig
);

  logic hyp_ok;   // hypervisor-visible sources allowed
  logic low_ok;   // mondo / error sources allowed

  always_comb begin
    hyp_ok = hyp_mode ? intr_en : 1'b1;
    low_ok = ~hyp_mode & intr_en;
    elig   = '0;
    elig[SRC_HSTICK] = pend[SRC_HSTICK] & hyp_ok;
    elig[SRC_VEC]    = pend[SRC_VEC]    & hyp_ok;
    elig[SRC_CPU]    = pend[SRC_CPU]    & low_ok;
    elig[SRC_DEV]    = pend[SRC_DEV]    & low_ok;
    elig[SRC_RES]    = pend[SRC_RES]    & low_ok;

    // R2: hypervisor mode with interrupts off admits nothing
    assert_hyp_masked_R2: assert (!(hyp_mode && !intr_en) || elig == '0);
    // R3: low sources never eligible in hypervisor mode
    assert_hyp_low_blocked_R3: assert (!hyp_mode ||
      (elig[SRC_CPU] | elig[SRC_DEV] | elig[SRC_RES]) == 1'b0);
    // R5: outside hypervisor mode with ie clear, low sources blocked
    assert_user_low_blocked_R5: assert (hyp_mode || intr_en ||
      (elig[SRC_CPU] | elig[SRC_DEV] | elig[SRC_RES]) == 1'b0);
    // eligibility never invents a request
    assert_elig_subset_R1: assert ((elig & ~pend) == '0);
  end

endmodule

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  // Index 0 wins; each higher index wins only if all lower indices are idle.
  for (genvar g = 0; g < N; g++) begin : g_chain
    if (g == 0) begin : g_top
      assign grant[g] = req[g];
    end else begin : g_rest
      assign grant[g] = req[g] & ~(|req[g-1:0]);
    end
  end

  always_comb begin
    // R1: at most one grant, always to a requester, and only if something asked
    assert_grant_onehot_R1: assert ($onehot0(grant));
    assert_grant_req_R1: assert ((grant & ~req) == '0);
    assert_grant_live_R6: assert ((req == '0) || (grant != '0));
  end

endmodule

// File: rtl/trap_irq_enc.sv
module trap_irq_enc #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] grant,
  output logic         valid,
  output logic [W-1:0] code
);

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = code | W'(i + 1);
    end
    valid = |grant;

    // R7: a valid selection carries a nonzero code within range
    assert_code_range_R7: assert (valid ? (code != '0 && code <= W'(N)) : code == '0);
  end

endmodule

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter
  import trap_irq_pkg::*;
(
  input  logic       pend_hstick,
  input  logic       pend_vec,
  input  logic       pend_cpu_mondo,
  input  logic       pend_dev_mondo,
  input  logic       pend_res_err,
  input  logic       hyp_mode,
  input  logic       intr_en,
  output logic       take_valid,
  output logic [2:0] take_kind
);

  logic [NUM_SRC-1:0] pend_vecs;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] grant;
  logic               sel_valid;
  logic [KIND_W-1:0]  sel_code;

  always_comb begin
    pend_vecs = '0;
    pend_vecs[SRC_HSTICK] = pend_hstick;
    pend_vecs[SRC_VEC]    = pend_vec;
    pend_vecs[SRC_CPU]    = pend_cpu_mondo;
    pend_vecs[SRC_DEV]    = pend_dev_mondo;
    pend_vecs[SRC_RES]    = pend_res_err;
  end

  trap_irq_gate u_gate (
    .pend     (pend_vecs),
    .hyp_mode (hyp_mode),
    .intr_en  (intr_en),
    .elig     (elig)
  );

  trap_irq_pick #(.N(NUM_SRC)) u_pick (
    .req   (elig),
    .grant (grant)
  );

  trap_irq_enc #(.N(NUM_SRC), .W(KIND_W)) u_enc (
    .grant (grant),
    .valid (sel_valid),
    .code  (sel_code)
  );

  assign take_valid = sel_valid;
  assign take_kind  = 3'(sel_code);

  always_comb begin
    // R4: outside hypervisor mode the tick always wins when pending
    assert_user_tick_R4: assert (hyp_mode || !pend_hstick ||
      (take_valid && take_kind == 3'(KIND_HSTICK)));
    // R1: vector beats every mondo/error source when eligible and tick idle
    assert_vec_over_low_R1: assert (hyp_mode || pend_hstick || !pend_vec ||
      take_kind == 3'(KIND_VEC));
    // R6: nothing pending means nothing taken
    assert_idle_R6: assert ((pend_vecs != '0) || (!take_valid && take_kind == '0));
  end

endmodule

// File: tb/trap_irq_arbiter_test.sv
module trap_irq_arbiter_test;

  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  logic pend_hstick, pend_vec, pend_cpu_mondo, pend_dev_mondo, pend_res_err;
  logic hyp_mode, intr_en;
  logic       take_valid;
  logic [2:0] take_kind;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  trap_irq_arbiter uut (
    .pend_hstick    (pend_hstick),
    .pend_vec       (pend_vec),
    .pend_cpu_mondo (pend_cpu_mondo),
    .pend_dev_mondo (pend_dev_mondo),
    .pend_res_err   (pend_res_err),
    .hyp_mode       (hyp_mode),
    .intr_en        (intr_en),
    .take_valid     (take_valid),
    .take_kind      (take_kind)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference from the requirements: bits {res,dev,cpu,vec,tick} in v[4:0], hyp v[5], ie v[6]
  function automatic logic [2:0] ref_kind(input logic [6:0] v);
    logic hy, ie;
    hy = v[5]; ie = v[6];
    if (hy) begin
      if (!ie) return 3'd0;
      if (v[0]) return 3'd1;
      if (v[1]) return 3'd2;
      return 3'd0;
    end
    if (v[0]) return 3'd1;
    if (v[1]) return 3'd2;
    if (!ie) return 3'd0;
    if (v[2]) return 3'd3;
    if (v[3]) return 3'd4;
    if (v[4]) return 3'd5;
    return 3'd0;
  endfunction

  task automatic drive(input logic [6:0] v);
    @(negedge clk);
    {intr_en, hyp_mode, pend_res_err, pend_dev_mondo, pend_cpu_mondo, pend_vec, pend_hstick} = v;
    #1;
  endtask

  task automatic check(input string req, input logic exp_v, input logic [2:0] exp_k);
    n_checks++;
    if (take_valid !== exp_v || take_kind !== exp_k) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b kind=%0d, expected valid=%0b kind=%0d",
               req, take_valid, take_kind, exp_v, exp_k);
    end
  endtask

  task automatic t_reset_state();
    check("R6 reset idle", 1'b0, 3'd0);
  endtask

  task automatic t_hyp_disabled();   // R2
    drive(7'b0_1_11111); check("R2 all pending hyp ie=0", 1'b0, 3'd0);
    drive(7'b0_1_00001); check("R2 tick hyp ie=0", 1'b0, 3'd0);
    drive(7'b0_1_00010); check("R2 vec hyp ie=0", 1'b0, 3'd0);
  endtask

  task automatic t_hyp_enabled();    // R3
    drive(7'b1_1_11100); check("R3 low sources hyp ie=1", 1'b0, 3'd0);
    drive(7'b1_1_11110); check("R3 vec hyp ie=1", 1'b1, 3'd2);
    drive(7'b1_1_11111); check("R3 tick hyp ie=1", 1'b1, 3'd1);
  endtask

  task automatic t_user_high();      // R4
    drive(7'b0_0_00001); check("R4 tick user ie=0", 1'b1, 3'd1);
    drive(7'b0_0_11110); check("R4 vec user ie=0", 1'b1, 3'd2);
    drive(7'b1_0_00010); check("R4 vec user ie=1", 1'b1, 3'd2);
  endtask

  task automatic t_user_disabled();  // R5
    drive(7'b0_0_11100); check("R5 low sources user ie=0", 1'b0, 3'd0);
    drive(7'b0_0_10000); check("R5 res err user ie=0", 1'b0, 3'd0);
  endtask

  task automatic t_priority_codes(); // R1, R7
    drive(7'b1_0_11100); check("R1 cpu over dev/res, R7 code 3", 1'b1, 3'd3);
    drive(7'b1_0_11000); check("R1 dev over res, R7 code 4", 1'b1, 3'd4);
    drive(7'b1_0_10000); check("R1 res alone, R7 code 5", 1'b1, 3'd5);
    drive(7'b1_0_00000); check("R6 none pending", 1'b0, 3'd0);
  endtask

  task automatic t_comb_follow();    // R8: change inputs mid-cycle, no edge
    @(posedge clk);
    #2;
    {intr_en, hyp_mode, pend_res_err, pend_dev_mondo, pend_cpu_mondo, pend_vec, pend_hstick} = 7'b1_0_01000;
    #1; check("R8 follow without edge a", 1'b1, 3'd4);
    pend_vec = 1'b1;
    #1; check("R8 follow without edge b", 1'b1, 3'd2);
  endtask

  task automatic t_exhaustive();     // R1..R7 over every combination
    for (int v = 0; v < 128; v++) begin
      logic [2:0] k;
      k = ref_kind(7'(v));
      drive(7'(v));
      check("R1 exhaustive", k != 3'd0, k);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    {intr_en, hyp_mode, pend_res_err, pend_dev_mondo, pend_cpu_mondo, pend_vec, pend_hstick} = '0;
    repeat (2) @(posedge clk);
    #1;
    t_reset_state();
    rst_n = 1'b1;
    t_hyp_disabled();
    t_hyp_enabled();
    t_user_high();
    t_user_disabled();
    t_priority_codes();
    t_comb_follow();
    t_exhaustive();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule